// File: doc/BRIEF.md
# IR Carrier Waveform Generator

This block turns the system clock into a square-wave infrared carrier whose high and low times can be set separately. A free-running prescaler makes a one-cycle tick every 1, 2, 4 or 8 system clocks. Two 8-bit settings give the number of ticks in each phase, minus one. Every carrier period starts with its high phase and ends with its low phase. A one-cycle strobe marks the end of each full period, so a downstream modulator can use it as a count enable.

The high and low settings are not used straight from the inputs. They are captured only when the modulator pulses its interval-start input. The carrier can therefore change duty cycle and frequency from one modulation interval to the next without a glitch. While the block is disabled, the prescaler and the phase counters are held cleared and the carrier stays low.

Top module: `ir_carrier_gen`

## Requirements
- R1: With `en` high, the prescaler emits a tick every 2^`div_sel` system clocks (`div_sel` 0,1,2,3 gives 1,2,4,8). The carrier changes level only on a tick.
- R2: The high phase lasts (captured high setting + 1) ticks, which is ((high+1) << `div_sel`) system clocks.
- R3: The low phase lasts (captured low setting + 1) ticks, which is ((low+1) << `div_sel`) system clocks.
- R4: Each period is the high phase followed by the low phase, so one period is high+low+2 ticks.
- R5: `hi_len` and `lo_len` are captured only in cycles where `ivl_start` is high, and they are held until the next such cycle. Changing them without `ivl_start` does not affect the carrier. A capture in the same cycle as a period end takes effect from the following period.
- R6: While `en` is low, `carrier` and `period_done` are low from the next cycle onward. The first clock edge that samples `en` high starts a new high phase, with the prescaler and phase count cleared.
- R7: `period_done` is a one-cycle pulse. It is asserted in the cycle where the carrier returns high at the end of a low phase, and it is never asserted on the first high phase after enable.
- R8: After reset, `carrier` and `period_done` are low and both captured settings are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low clears the prescaler and phase counters |
| div_sel | input | 2 | Tick divider select: divide by 2^div_sel |
| hi_len | input | 8 | High phase length in ticks, minus one |
| lo_len | input | 8 | Low phase length in ticks, minus one |
| ivl_start | input | 1 | Interval-start pulse; captures hi_len and lo_len |
| carrier | output | 1 | Raw carrier level |
| period_done | output | 1 | One-cycle strobe at each carrier period boundary |

## Verification
Two events can land on the same clock edge: the tick that ends a low phase and an interval-start capture of new settings. The bench counts the low samples of a running period and raises `ivl_start` with a new setting pair in exactly the cycle whose closing edge ends that low phase. It then expects the period to close on the old low length, with `period_done` and the rising carrier arriving together. The next high and low phases must use the new lengths. The phase lengths are also measured for the settings 0 and 255 at every divider value, and for seeded random settings.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CW = 8,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div_sel,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  input  logic          ivl_start,
  output logic          carrier,
  output logic          period_done
);
  localparam int PW = (1 << DW) - 1;

  logic [PW-1:0] pcnt, plim;
  logic          tick, act, ph_hi;
  logic [CW-1:0] cnt, hi_q, lo_q;

  assign plim    = {PW{1'b1}} >> (PW - int'(div_sel));
  assign tick    = (pcnt == '0);
  assign carrier = act & ph_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pcnt <= '0;
    else if (!en || pcnt >= plim) pcnt <= '0;
    else                       pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (ivl_start) begin
      hi_q <= hi_len;
      lo_q <= lo_len;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; ph_hi <= 1'b1; cnt <= '0; period_done <= 1'b0;
    end else if (!en) begin
      act <= 1'b0; ph_hi <= 1'b1; cnt <= '0; period_done <= 1'b0;
    end else begin
      period_done <= 1'b0;
      if (tick) begin
        if (!act) begin
          act <= 1'b1; ph_hi <= 1'b1; cnt <= '0;
        end else if (ph_hi) begin
          if (cnt == hi_q) begin ph_hi <= 1'b0; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end else begin
          if (cnt == lo_q) begin ph_hi <= 1'b1; cnt <= '0; period_done <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
      end
    end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!carrier && !period_done));

  p_tick_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(carrier));

  p_done_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (carrier && !$past(carrier)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ivl_start |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_sel = '0;
  logic [7:0] hi_len = '0, lo_len = '0;
  logic       ivl_start = 1'b0;
  logic       carrier, period_done;
  int         checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ir_carrier_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
    .hi_len(hi_len), .lo_len(lo_len), .ivl_start(ivl_start),
    .carrier(carrier), .period_done(period_done)
  );

  function automatic int phase_cycles(input int v, input int d);
    return (v + 1) << d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at a negedge where carrier has just gone high (one sample counted).
  task automatic measure(input int h, input int l, input int d, input string tag);
    int n = 1, m = 0, extra_done = 0;
    while (1) begin
      @(negedge clk);
      if (!carrier) break;
      n++;
      if (n > 5000) break;
    end
    chk(n == phase_cycles(h, d), {tag, " R2 high length"}, n, phase_cycles(h, d));
    if (h == 0) chk(n == (1 << d), {tag, " R1 tick spacing"}, n, 1 << d);
    m = 1;
    while (1) begin
      @(negedge clk);
      if (carrier) break;
      if (period_done) extra_done++;
      m++;
      if (m > 5000) break;
    end
    chk(m == phase_cycles(l, d), {tag, " R3 low length"}, m, phase_cycles(l, d));
    chk(n + m == ((h + l + 2) << d), {tag, " R4 period"}, n + m, (h + l + 2) << d);
    chk(period_done && extra_done == 0, {tag, " R7 strobe at boundary"},
        int'(period_done), 1);
  endtask

  task automatic run_case(input int h, input int l, input int d, input string tag);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!carrier && !period_done, {tag, " R6 idle low"}, int'(carrier), 0);
    hi_len = 8'(h); lo_len = 8'(l); ivl_start = 1'b1;
    @(negedge clk);
    ivl_start = 1'b0; div_sel = 2'(d); en = 1'b1;
    @(negedge clk);
    chk(carrier && !period_done, {tag, " R6 R7 start high, no strobe"}, int'(carrier), 1);
    measure(h, l, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int h, l, d, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!carrier && !period_done, "R8 reset outputs", int'(carrier), 0);
    rst_n = 1'b1;
    // R8: captured settings are zero after reset -> one-tick phases.
    @(negedge clk);
    en = 1'b1; div_sel = 2'd0;
    @(negedge clk);
    measure(0, 0, 0, "R8 zero settings");
    // Corner values at every divider.
    for (int dv = 0; dv < 4; dv++) begin
      run_case(0, 0, dv, "corner 0/0");
      run_case(255, 255, dv, "corner 255/255");
      run_case(0, 255, dv, "corner 0/255");
      run_case(255, 0, dv, "corner 255/0");
    end
    // R5: input change without ivl_start has no effect.
    @(negedge clk);
    en = 1'b0;
    hi_len = 8'd4; lo_len = 8'd2; ivl_start = 1'b1;
    @(negedge clk);
    ivl_start = 1'b0; hi_len = 8'd9; lo_len = 8'd7; div_sel = 2'd1; en = 1'b1;
    @(negedge clk);
    measure(4, 2, 1, "R5 ignored inputs");
    // R5: capture collides with the period-ending tick.
    run_case(3, 5, 0, "R5 pre-collision");
    n = 1;
    while (carrier) @(negedge clk);
    while (n < 6) begin @(negedge clk); n++; end
    hi_len = 8'd6; lo_len = 8'd1; ivl_start = 1'b1;
    @(negedge clk);
    ivl_start = 1'b0;
    chk(period_done && carrier, "R5 R7 collision keeps old low", int'(period_done), 1);
    measure(6, 1, 0, "R5 new settings after collision");
    // R6: disable mid high phase, then restart with full high phase.
    run_case(20, 3, 0, "R6 setup");
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!carrier, "R6 disable drops carrier", int'(carrier), 0);
    en = 1'b1;
    @(negedge clk);
    chk(carrier, "R6 restart high", int'(carrier), 1);
    measure(20, 3, 0, "R6 restart");
    // Random settings.
    for (int i = 0; i < 20; i++) begin
      h = int'($urandom_range(255)); l = int'($urandom_range(255));
      d = int'($urandom_range(3));
      run_case(h, l, d, "random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule